// File: doc/BRIEF.md
# Byte-Lane Single-Port Synchronous RAM

This block is a single-port synchronous RAM for one clock. Each enabled edge takes one address, an optional write with per-lane masking, and an optional read. The read returns the word that was stored before any write in that same edge. Read data comes out of a read latch, and an optional output register can follow it. That register can be cleared asynchronously, synchronously, or both. A force-to-zero mode drives the output to zero for any read slot in which the read enable was low.

An address-stall input keeps the captured address for one or more edges. During a stall, both the read and the write use the held word address, and the address bus is ignored. The input stage and the output register each have their own clock enable. The array starts as all zeros. The block has no streaming data path, so every pin is a plain control or data pin with no handshake.

Top module: `bytelane_spram`

## Requirements
- R1: Before any write, every word reads as zero, and before the first clock edge `q` is zero.
- R2: DATA_W is a whole multiple of BYTE_W. A write changes only the lanes whose `byte_en` bit is 1, where bit i selects `wr_data[i*BYTE_W +: BYTE_W]`. Lanes whose bit is 0 keep their old contents.
- R3: When a read and a write hit the same word on the same edge, the read returns the contents from before that write.
- R4: With OUT_REG=0, a word read at edge k is on `q` after edge k. With OUT_REG=1, it is on `q` after edge k+1.
- R5: When `addr_stall` is 1 on an enabled edge, the read and the write use the last captured address, and `addr` is ignored. The captured address stays unchanged.
- R6: With FTZ=1, `q` is all zeros for a read slot whose `rd_en` was 0.
- R7: With FTZ=0, a slot whose `rd_en` is 0 leaves `q` at its previous value.
- R8: With OUT_REG=1, a 1 on `aclr` zeroes the output register at once, with no clock edge. This clear wins over `sclr` and over capture.
- R9: With OUT_REG=1, `sclr` high at an edge zeroes the output register, whatever the value of `out_ce`. This clear wins over capture.
- R10: An edge with `in_ce` at 0 performs no read and no write, and it leaves the captured address unchanged.
- R11: With OUT_REG=1, an edge with `out_ce` at 0 and `sclr` at 0 leaves `q` unchanged.
- R12: The clears affect only the output register. The array contents and the read latch are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| in_ce | input | 1 | Clock enable for the address, write and read stage |
| out_ce | input | 1 | Clock enable for the output register |
| aclr | input | 1 | Asynchronous clear of the output register, active high |
| sclr | input | 1 | Synchronous clear of the output register, active high |
| addr_stall | input | 1 | Hold the captured address and ignore `addr` |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| byte_en | input | DATA_W/BYTE_W | Per-lane write mask, bit i selects lane i |
| rd_en | input | 1 | Read request |
| q | output | DATA_W | Read data |

## Verification
A corrupted array word or a wrongly masked lane stays hidden until that word is read again. It then shows on `q` one edge after the read without the output register, or two edges after it with the register. A held address that slips shows up on the first stalled access, as data from the wrong word. An error in the read-enable flag that travels beside the output register shows up as a zeroed or non-zeroed word, on the same edge as the data it belongs to. A clear that leaks into the read latch shows on the following capture, as a zero in place of the expected word.

// File: rtl/spram_pkg.sv
package spram_pkg;

  // Lane count for a word of dw bits split into lanes of bw bits; zero flags a bad split.
  function automatic int lanes_for(input int dw, input int bw);
    if (bw <= 0) return 0;
    return ((dw % bw) == 0) ? (dw / bw) : 0;
  endfunction

  // Encodes which action the output register takes on a given edge.
  typedef enum logic [1:0] {
    OUT_HOLD    = 2'd0,
    OUT_CAPTURE = 2'd1,
    OUT_SCLEAR  = 2'd2
  } out_act_e;

endpackage

// File: rtl/spram_addr_stage.sv
module spram_addr_stage #(
  parameter int ADDR_W   = 8,
  parameter int LANES    = 4,
  parameter bit USE_BE   = 1'b1,
  parameter bit USE_RDEN = 1'b1
) (
  input  logic              clk,
  input  logic              in_ce,
  input  logic              addr_stall,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [LANES-1:0]  byte_en,
  input  logic              rd_en,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] addr_hold,
  output logic              rd_go,
  output logic [LANES-1:0]  lane_we,
  output logic              rd_flag
);

  logic [ADDR_W-1:0] hold_q = '0;
  logic              flag_q = 1'b0;
  logic              rd_req;
  logic              wr_go;

  // A stalled edge reuses the held address for both the read and the write.
  assign eff_addr = addr_stall ? hold_q : addr;

  always_ff @(posedge clk) begin
    if (in_ce && !addr_stall) hold_q <= addr;
  end

  generate
    if (USE_RDEN) begin : g_rden
      assign rd_req = rd_en;
    end else begin : g_nordn
      assign rd_req = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (in_ce) flag_q <= rd_req;
  end

  assign rd_go = in_ce & rd_req;
  assign wr_go = in_ce & wr_en;

  generate
    if (USE_BE) begin : g_mask
      assign lane_we = {LANES{wr_go}} & byte_en;
    end else begin : g_full
      assign lane_we = {LANES{wr_go}};
    end
  endgenerate

  assign addr_hold = hold_q;
  assign rd_flag   = flag_q;

endmodule

// File: rtl/spram_lane.sv
module spram_lane #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH] = '{default: '0};
  logic [BYTE_W-1:0] rd_q = '0;

  // Non-blocking update: a read on the same edge sees the pre-write value.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rd_q      <= mem[addr];
  end

  assign rdata = rd_q;

endmodule

// File: rtl/spram_out_stage.sv
module spram_out_stage
  import spram_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit OUT_REG  = 1'b1,
  parameter bit FTZ      = 1'b1,
  parameter bit USE_ACLR = 1'b1,
  parameter bit USE_SCLR = 1'b1
) (
  input  logic              clk,
  input  logic              out_ce,
  input  logic              aclr,
  input  logic              sclr,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              rd_flag,
  output logic [DATA_W-1:0] q
);

  generate
    if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] oq = '0;
      logic              flag2 = 1'b0;
      logic              aclr_e;
      logic              sclr_e;
      out_act_e          act;

      assign aclr_e = USE_ACLR & aclr;
      assign sclr_e = USE_SCLR & sclr;

      always_comb begin
        if (sclr_e)      act = OUT_SCLEAR;
        else if (out_ce) act = OUT_CAPTURE;
        else             act = OUT_HOLD;
      end

      always_ff @(posedge clk or posedge aclr_e) begin
        if (aclr_e) begin
          oq <= '0;
        end else begin
          case (act)
            OUT_SCLEAR:  oq <= '0;
            OUT_CAPTURE: oq <= rd_word;
            default:     oq <= oq;
          endcase
        end
      end

      // The read-enable flag travels beside the data so that zeroing lines up with it.
      always_ff @(posedge clk) begin
        if (out_ce) flag2 <= rd_flag;
      end

      if (FTZ) begin : g_ftz
        assign q = flag2 ? oq : '0;
      end else begin : g_pass
        assign q = oq;
      end
    end else begin : g_flow
      if (FTZ) begin : g_ftz
        assign q = rd_flag ? rd_word : '0;
      end else begin : g_pass
        assign q = rd_word;
      end
    end
  endgenerate

endmodule

// File: rtl/bytelane_spram.sv
module bytelane_spram #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter bit OUT_REG  = 1'b1,
  parameter bit FTZ      = 1'b1,
  parameter bit USE_BE   = 1'b1,
  parameter bit USE_RDEN = 1'b1,
  parameter bit USE_ACLR = 1'b1,
  parameter bit USE_SCLR = 1'b1
) (
  input  logic                     clk,
  input  logic                     in_ce,
  input  logic                     out_ce,
  input  logic                     aclr,
  input  logic                     sclr,
  input  logic                     addr_stall,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W/BYTE_W-1:0] byte_en,
  input  logic                     rd_en,
  output logic [DATA_W-1:0]        q
);

  localparam int LANES = spram_pkg::lanes_for(DATA_W, BYTE_W);

  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] addr_hold;
  logic              rd_go;
  logic              rd_flag;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rd_word;

  spram_addr_stage #(
    .ADDR_W  (ADDR_W),
    .LANES   (LANES),
    .USE_BE  (USE_BE),
    .USE_RDEN(USE_RDEN)
  ) u_addr (
    .clk       (clk),
    .in_ce     (in_ce),
    .addr_stall(addr_stall),
    .addr      (addr),
    .wr_en     (wr_en),
    .byte_en   (byte_en),
    .rd_en     (rd_en),
    .eff_addr  (eff_addr),
    .addr_hold (addr_hold),
    .rd_go     (rd_go),
    .lane_we   (lane_we),
    .rd_flag   (rd_flag)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      spram_lane #(
        .ADDR_W(ADDR_W),
        .BYTE_W(BYTE_W)
      ) u_lane (
        .clk  (clk),
        .we   (lane_we[l]),
        .re   (rd_go),
        .addr (eff_addr),
        .wdata(wr_data[l*BYTE_W +: BYTE_W]),
        .rdata(rd_word[l*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

  spram_out_stage #(
    .DATA_W  (DATA_W),
    .OUT_REG (OUT_REG),
    .FTZ     (FTZ),
    .USE_ACLR(USE_ACLR),
    .USE_SCLR(USE_SCLR)
  ) u_out (
    .clk    (clk),
    .out_ce (out_ce),
    .aclr   (aclr),
    .sclr   (sclr),
    .rd_word(rd_word),
    .rd_flag(rd_flag),
    .q      (q)
  );

endmodule

// File: rtl/spram_chk.sv
module spram_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter bit OUT_REG  = 1'b1,
  parameter bit FTZ      = 1'b1,
  parameter bit USE_RDEN = 1'b1,
  parameter bit USE_ACLR = 1'b1,
  parameter bit USE_SCLR = 1'b1
) (
  input logic              clk,
  input logic              in_ce,
  input logic              out_ce,
  input logic              aclr,
  input logic              sclr,
  input logic              addr_stall,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] q
);

  // R5 / R10: the captured address moves only on an enabled, non-stalled edge.
  a_r5_addr_held: assert property (@(posedge clk) disable iff (aclr)
    (addr_stall || !in_ce) |=> $stable(addr_q));

  generate
    if (OUT_REG) begin : g_reg
      if (USE_ACLR) begin : g_aclr
        // R8: the output reads zero on any edge where the asynchronous clear is high.
        a_r8_aclr_zero: assert property (@(posedge clk) aclr |-> q == '0);
      end
      if (USE_SCLR) begin : g_sclr
        // R9
        a_r9_sclr_zero: assert property (@(posedge clk) disable iff (aclr)
          sclr |=> q == '0);
      end
      // R11
      a_r11_out_hold: assert property (@(posedge clk) disable iff (aclr)
        (!out_ce && !(USE_SCLR && sclr)) |=> $stable(q));
      if (FTZ && USE_RDEN) begin : g_ftz
        // R6
        a_r6_ftz_zero: assert property (@(posedge clk) disable iff (aclr)
          (in_ce && !rd_en) ##1 out_ce |=> q == '0);
      end
    end else begin : g_flow
      if (FTZ && USE_RDEN) begin : g_ftz
        // R6
        a_r6_ftz_zero: assert property (@(posedge clk) disable iff (aclr)
          (in_ce && !rd_en) |=> q == '0);
      end
      if (!FTZ && USE_RDEN) begin : g_keep
        // R7
        a_r7_keep_q: assert property (@(posedge clk) disable iff (aclr)
          (!in_ce || !rd_en) |=> $stable(q));
      end
    end
  endgenerate

endmodule

bind bytelane_spram spram_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .OUT_REG (OUT_REG),
  .FTZ     (FTZ),
  .USE_RDEN(USE_RDEN),
  .USE_ACLR(USE_ACLR),
  .USE_SCLR(USE_SCLR)
) i_spram_chk (
  .clk       (clk),
  .in_ce     (in_ce),
  .out_ce    (out_ce),
  .aclr      (aclr),
  .sclr      (sclr),
  .addr_stall(addr_stall),
  .rd_en     (rd_en),
  .addr_q    (addr_hold),
  .q         (q)
);

// File: tb/test_bytelane_spram.sv
`timescale 1ns/1ps
module test_bytelane_spram;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = 8;
  localparam int NL = DW / BW;

  logic          clk = 1'b0;
  logic          in_ce = 1'b0, out_ce = 1'b0, aclr = 1'b0, sclr = 1'b0;
  logic          addr_stall = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NL-1:0] byte_en = '0;
  logic [DW-1:0] qa, qb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  // Registered output, force-to-zero on.
  bytelane_spram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW)) i_bytelane_spram (
    .clk(clk), .in_ce(in_ce), .out_ce(out_ce), .aclr(aclr), .sclr(sclr),
    .addr_stall(addr_stall), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .byte_en(byte_en), .rd_en(rd_en), .q(qa));

  // Latch output only, force-to-zero off.
  bytelane_spram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW), .OUT_REG(1'b0), .FTZ(1'b0))
  i_bytelane_spram_flow (
    .clk(clk), .in_ce(in_ce), .out_ce(out_ce), .aclr(aclr), .sclr(sclr),
    .addr_stall(addr_stall), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .byte_en(byte_en), .rd_en(rd_en), .q(qb));

  // Behavioural reference.
  logic [DW-1:0] m_mem [1 << AW];
  logic [AW-1:0] m_aq = '0;
  logic [AW-1:0] m_ea;
  logic [DW-1:0] m_lat = '0;
  logic [DW-1:0] m_oq = '0;
  logic          m_rq = 1'b0;
  logic          m_en2 = 1'b0;

  initial for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;

  always @(posedge clk) begin
    m_ea = addr_stall ? m_aq : addr;
    if (aclr || sclr) m_oq = '0;
    else if (out_ce)  m_oq = m_lat;
    if (out_ce) m_en2 = m_rq;
    if (in_ce) begin
      if (rd_en) m_lat = m_mem[m_ea];
      m_rq = rd_en;
      if (wr_en)
        for (int l = 0; l < NL; l++)
          if (byte_en[l]) m_mem[m_ea][l*BW +: BW] = wr_data[l*BW +: BW];
      if (!addr_stall) m_aq = addr;
    end
  end

  function automatic logic [DW-1:0] exp_reg();
    return m_en2 ? m_oq : '0;
  endfunction

  function automatic logic [DW-1:0] exp_flow();
    return m_lat;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    check({tag, " reg-out"}, qa, exp_reg());
    check({tag, " flow-out"}, qb, exp_flow());
  endtask

  task automatic idle();
    in_ce = 1'b1; out_ce = 1'b1; rd_en = 1'b1;
    aclr = 1'b0; sclr = 1'b0; addr_stall = 1'b0; wr_en = 1'b0;
    byte_en = '1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1 power-up reg-out", qa, '0);
    check("R1 power-up flow-out", qb, '0);
    @(negedge clk);

    // R1: unwritten words read zero
    idle(); addr = 8'd5;
    tick("R1 zero word");
    tick("R1 zero word");
    check("R1 zero word explicit", qa, '0);

    // R2: lane masking
    wr_en = 1'b1; addr = 8'd3; wr_data = 32'hAABBCCDD; byte_en = 4'b1111;
    tick("R2 full write");
    wr_data = 32'h11223344; byte_en = 4'b0101;
    tick("R2 masked write");
    wr_en = 1'b0;
    tick("R2 readback");
    check("R2 lanes 0,2 written", qb, 32'hAA22CC44);

    // R3: old data on same-address read/write
    wr_en = 1'b1; wr_data = 32'hDEADBEEF; byte_en = 4'b1111;
    tick("R3 rdw");
    check("R3 old data", qb, 32'hAA22CC44);

    // R4: latency of each output path
    wr_en = 1'b0;
    tick("R4 latency");
    check("R4 flow after one edge", qb, 32'hDEADBEEF);
    check("R4 reg lags one edge", qa, 32'hAA22CC44);
    tick("R4 latency");
    check("R4 reg after two edges", qa, 32'hDEADBEEF);

    // R5: stall reuses held address 3 for read and write
    addr_stall = 1'b1; addr = 8'd9; wr_en = 1'b1; wr_data = 32'h01020304;
    tick("R5 stalled rdw");
    check("R5 stalled read word 3", qb, 32'hDEADBEEF);
    addr_stall = 1'b0; wr_en = 1'b0;
    tick("R5 word 9");
    check("R5 word 9 untouched", qb, '0);
    addr = 8'd3;
    tick("R5 word 3");
    check("R5 write landed on 3", qb, 32'h01020304);

    // R6 / R7: read enable low
    rd_en = 1'b0;
    tick("R6 ftz");
    tick("R6 ftz");
    check("R6 zero output", qa, '0);
    check("R7 flow output kept", qb, 32'h01020304);

    // R11: output register held with out_ce low
    rd_en = 1'b1;
    tick("R11 prep");
    tick("R11 prep");
    out_ce = 1'b0; addr = 8'd9;
    tick("R11 hold");
    tick("R11 hold");
    check("R11 reg held", qa, 32'h01020304);
    check("R11 flow advanced", qb, '0);

    // R9: sync clear regardless of out_ce
    sclr = 1'b1;
    tick("R9 sclr");
    check("R9 cleared", qa, '0);
    sclr = 1'b0; out_ce = 1'b1; addr = 8'd3;
    tick("R12 after sclr");
    tick("R12 after sclr");
    check("R12 memory intact after sclr", qa, 32'h01020304);

    // R8: asynchronous clear, over capture
    aclr = 1'b1;
    #1;
    check("R8 async zero", qa, '0);
    check("R12 latch untouched by aclr", qb, 32'h01020304);
    sclr = 1'b1;
    tick("R8 aclr over capture");
    check("R8 still zero", qa, '0);
    aclr = 1'b0; sclr = 1'b0;
    tick("R12 after aclr");
    check("R12 capture resumes", qa, 32'h01020304);

    // R10: in_ce low blocks write and read
    in_ce = 1'b0; wr_en = 1'b1; wr_data = 32'hFFFFFFFF; addr = 8'd3;
    tick("R10 gated");
    addr = 8'd7;
    tick("R10 gated");
    in_ce = 1'b1; wr_en = 1'b0; addr_stall = 1'b1;
    tick("R10 held addr");
    check("R10 no write, address kept", qb, 32'h01020304);
    addr_stall = 1'b0;

    // Random mix: R2 R3 R4 R5 R6 R9 R10 R11
    for (int n = 0; n < 2500; n++) begin
      in_ce      = ($urandom_range(0, 9) != 0);
      out_ce     = ($urandom_range(0, 9) != 0);
      addr_stall = ($urandom_range(0, 6) == 0);
      wr_en      = ($urandom_range(0, 9) < 4);
      rd_en      = ($urandom_range(0, 4) != 0);
      sclr       = ($urandom_range(0, 31) == 0);
      byte_en    = NL'($urandom);
      wr_data    = $urandom;
      addr       = ($urandom_range(0, 7) == 0) ? AW'($urandom) : AW'($urandom_range(0, 7));
      tick("R2 R3 R4 R5 R6 R9 R10 R11 random");
    end

    done = 1'b1;
    summary();
  end

endmodule